// File: doc/BRIEF.md
# Serial-Latched Quad Output Driver Control

This block is the digital control logic for a four-channel low-side output driver programmed over a shift-register serial link. A controller clocks channel bits in on a serial data input under a serial shift clock. A rising edge on a separate load strobe commits the shifted word to the channel outputs. The same strobe loads the sticky per-channel fault status into the shift path. On the next transfer the controller reads the fault status back out while it clocks in the following word.

Several instances can share the shift clock, load strobe, clear and fault line, with each serial output wired to the next serial input. In such a chain, bits for the farthest instance are sent first. An active-high enable-blocking input gates the channel drive signals and leaves the serial logic running. The fault line is open-drain: the block asserts a pull-down request whenever any sticky fault is held.

All logic runs from one system clock. The shift clock, load strobe and serial data are passed through a synchronizer and edge-detected, so the serial link must run several times slower than the system clock.

Top module: `quad_serial_drv_ctrl`

## Requirements
- R1: Serial data is sampled on each synchronized rising edge of `shift_clk` and enters the shift register at its LSB. The first bit of a four-bit word therefore ends in channel 4 (`drive_en[3]`) and the last bit ends in channel 1 (`drive_en[0]`).
- R2: `drive_en` keeps its previous value during shifting. It takes the shifted word only after a synchronized rising edge of `load_strobe`.
- R3: A rising edge of `load_strobe` loads the sticky fault bits into the shift register, with channel 4 in the MSB, and drives `chain_dout` to the channel-4 fault bit at once. The channel 3, 2 and 1 fault bits follow on successive falling edges of `shift_clk`.
- R4: `chain_dout` changes only on a synchronized falling edge of `shift_clk`, where it takes the shift register MSB, or on a load event or a clear. Data written earlier therefore passes through to the next device in a chain.
- R5: When a load edge and a shift-clock rising edge are detected in the same system cycle, the load wins and the serial bit of that edge is discarded.
- R6: Each `fault_flags` bit sets a sticky fault bit that holds until a clear. `fault_pull` goes high whenever any sticky bit is set.
- R7: `rst` (power-up) or `clear_req` clears the shift register, output register, sticky faults, `chain_dout`, `drive_en` and `fault_pull` on the next clock.
- R8: While `drive_disable` is high, `drive_en` is all zero. The shift, load and fault-capture behaviour is unaffected, and the committed word reappears once `drive_disable` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| chain_din | input | 1 | Serial data in (from the previous device or the controller) |
| shift_clk | input | 1 | Serial shift clock, asynchronous to clk |
| load_strobe | input | 1 | Rising edge commits the word and captures faults |
| clear_req | input | 1 | Synchronous active-high clear of all serial and fault state |
| drive_disable | input | 1 | High forces all channel drives off |
| fault_flags | input | NCH | Per-channel fault detect inputs, bit 3 = channel 4 |
| chain_dout | output | 1 | Serial data out to the next device |
| drive_en | output | NCH | Channel drive enables, bit 3 = channel 4 |
| fault_pull | output | 1 | High requests the open-drain fault line be pulled low |

## Verification
The assertions check four behaviours on every cycle. A clear empties all outputs on the following cycle. The disable input blanks the drives one cycle later. The fault pull-down, once raised, persists until a clear. `chain_dout` holds steady unless a falling shift edge, a load or a clear occurs. Bit order, the load-before-shift priority, fault readback through the shift path and pass-through of earlier data only appear across whole transfers. The bench shows these with directed sequences and random traffic, compared cycle by cycle against a behavioural model.

// File: rtl/qsd_pkg.sv
package qsd_pkg;
  // action taken on the serial shift path in one system cycle
  typedef enum logic [1:0] {
    PATH_HOLD    = 2'd0,
    PATH_SHIFT   = 2'd1,
    PATH_CAPTURE = 2'd2
  } path_act_t;
endpackage

// File: rtl/qsd_edge_sync.sv
module qsd_edge_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= raw_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stg[STAGES-1];
  end

  assign lvl  = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev_q;
  assign fall = ~stg[STAGES-1] & prev_q;
endmodule

// File: rtl/qsd_shift_path.sv
module qsd_shift_path
  import qsd_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           clr,
  input  path_act_t      act,
  input  logic           sclk_fall,
  input  logic           din,
  input  logic [NCH-1:0] load_val,
  output logic [NCH-1:0] sreg,
  output logic           dout
);
  always_ff @(posedge clk) begin
    if (clr) begin
      sreg <= '0;
      dout <= 1'b0;
    end else begin
      unique case (act)
        PATH_CAPTURE: begin
          sreg <= load_val;
          dout <= load_val[NCH-1];
        end
        PATH_SHIFT: sreg <= {sreg[NCH-2:0], din};
        default: if (sclk_fall) dout <= sreg[NCH-1];
      endcase
    end
  end
endmodule

// File: rtl/qsd_fault_keep.sv
module qsd_fault_keep #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           clr,
  input  logic [NCH-1:0] flags_in,
  output logic [NCH-1:0] sticky,
  output logic           pull
);
  always_ff @(posedge clk) begin
    if (clr) begin
      sticky <= '0;
      pull   <= 1'b0;
    end else begin
      sticky <= sticky | flags_in;
      pull   <= |sticky;
    end
  end
endmodule

// File: rtl/quad_serial_drv_ctrl.sv
module quad_serial_drv_ctrl
  import qsd_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           chain_din,
  input  logic           shift_clk,
  input  logic           load_strobe,
  input  logic           clear_req,
  input  logic           drive_disable,
  input  logic [NCH-1:0] fault_flags,
  output logic           chain_dout,
  output logic [NCH-1:0] drive_en,
  output logic           fault_pull
);
  localparam int NPIN  = 3;
  localparam int P_DIN = 0;
  localparam int P_SCK = 1;
  localparam int P_LAT = 2;

  logic [NPIN-1:0] pin_lvl, pin_rise, pin_fall;
  logic            clr;
  logic            sclk_rise, sclk_fall, lat_rise;
  path_act_t       act;
  logic [NCH-1:0]  sreg, sticky, out_q;

  qsd_edge_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_in ({load_strobe, shift_clk, chain_din}),
    .lvl    (pin_lvl),
    .rise   (pin_rise),
    .fall   (pin_fall)
  );

  assign clr       = rst | clear_req;
  assign sclk_rise = pin_rise[P_SCK];
  assign sclk_fall = pin_fall[P_SCK];
  assign lat_rise  = pin_rise[P_LAT];

  // load has priority over a coincident shift edge
  always_comb begin
    if (lat_rise)       act = PATH_CAPTURE;
    else if (sclk_rise) act = PATH_SHIFT;
    else                act = PATH_HOLD;
  end

  qsd_fault_keep #(.NCH(NCH)) u_fault (
    .clk      (clk),
    .clr      (clr),
    .flags_in (fault_flags),
    .sticky   (sticky),
    .pull     (fault_pull)
  );

  qsd_shift_path #(.NCH(NCH)) u_path (
    .clk       (clk),
    .clr       (clr),
    .act       (act),
    .sclk_fall (sclk_fall),
    .din       (pin_lvl[P_DIN]),
    .load_val  (sticky),
    .sreg      (sreg),
    .dout      (chain_dout)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      out_q    <= '0;
      drive_en <= '0;
    end else begin
      if (lat_rise) out_q <= sreg;
      drive_en <= out_q & ~{NCH{drive_disable}};
    end
  end
endmodule

// File: rtl/qsd_chk.sv
module qsd_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           clear_req,
  input logic           drive_disable,
  input logic [NCH-1:0] drive_en,
  input logic           chain_dout,
  input logic           fault_pull,
  input logic           sclk_fall,
  input logic           lat_rise
);
  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clear_req |=> (drive_en == '0) && !chain_dout && !fault_pull);

  // R8
  disable_blanks_chk: assert property (@(posedge clk) disable iff (rst)
    drive_disable |=> (drive_en == '0));

  // R6
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_pull && !clear_req) |=> fault_pull);

  // R4
  dout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!sclk_fall && !lat_rise && !clear_req) |=> $stable(chain_dout));
endmodule

bind quad_serial_drv_ctrl qsd_chk #(.NCH(NCH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .clear_req     (clear_req),
  .drive_disable (drive_disable),
  .drive_en      (drive_en),
  .chain_dout    (chain_dout),
  .fault_pull    (fault_pull),
  .sclk_fall     (sclk_fall),
  .lat_rise      (lat_rise)
);

// File: tb/quad_serial_drv_ctrl_tb.sv
`timescale 1ns/1ps
module quad_serial_drv_ctrl_tb;
  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chain_din = 1'b0, shift_clk = 1'b0, load_strobe = 1'b0;
  logic       clear_req = 1'b0, drive_disable = 1'b0;
  logic [3:0] fault_flags = '0;
  logic       chain_dout, fault_pull;
  logic [3:0] drive_en;

  int n_cmp = 0, n_bad = 0;
  bit started = 0;

  always #4 clk = ~clk;

  quad_serial_drv_ctrl u_dut (
    .clk(clk), .rst(rst), .chain_din(chain_din), .shift_clk(shift_clk),
    .load_strobe(load_strobe), .clear_req(clear_req),
    .drive_disable(drive_disable), .fault_flags(fault_flags),
    .chain_dout(chain_dout), .drive_en(drive_en), .fault_pull(fault_pull)
  );

  // behavioural reference model
  logic [3:0] m_sreg = '0, m_out = '0, m_den = '0, m_fq = '0;
  logic       m_dout = 1'b0, m_fpull = 1'b0;
  logic [2:0] sh = '0, lh = '0, dh = '0; // [0]=1 edge ago, [1]=2 ago, [2]=3 ago

  always @(posedge clk) begin : model
    logic r_lat, r_sc, f_sc;
    logic [3:0] fq_old, out_old;
    started = 1;
    if (rst) begin
      m_sreg = '0; m_out = '0; m_den = '0; m_fq = '0; m_dout = 0; m_fpull = 0;
      sh = '0; lh = '0; dh = '0;
    end else begin
      r_lat = lh[1] & ~lh[2];
      r_sc  = sh[1] & ~sh[2];
      f_sc  = ~sh[1] & sh[2];
      fq_old = m_fq; out_old = m_out;
      if (clear_req) begin
        m_sreg = '0; m_out = '0; m_den = '0; m_fq = '0; m_dout = 0; m_fpull = 0;
      end else begin
        m_fpull = |fq_old;
        m_fq    = fq_old | fault_flags;
        m_den   = drive_disable ? 4'b0 : out_old;
        if (r_lat) begin
          m_out = m_sreg; m_sreg = fq_old; m_dout = fq_old[3];
        end else if (r_sc) begin
          m_sreg = {m_sreg[2:0], dh[1]};
        end else if (f_sc) begin
          m_dout = m_sreg[3];
        end
      end
      sh = {sh[1:0], shift_clk};
      lh = {lh[1:0], load_strobe};
      dh = {dh[1:0], chain_din};
    end
  end

  always @(negedge clk) begin
    if (started) begin
      n_cmp += 3;
      if (chain_dout !== m_dout) begin
        n_bad++; $display("FAIL R4 chain_dout act=%b exp=%b t=%0t", chain_dout, m_dout, $time);
      end
      if (drive_en !== m_den) begin
        n_bad++; $display("FAIL R2 drive_en act=%b exp=%b t=%0t", drive_en, m_den, $time);
      end
      if (fault_pull !== m_fpull) begin
        n_bad++; $display("FAIL R6 fault_pull act=%b exp=%b t=%0t", fault_pull, m_fpull, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++; $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shift a word, first element sent first; returns dout seen before each rise
  task automatic send_word(input logic [3:0] w, output logic [3:0] seen);
    for (int i = 3; i >= 0; i--) begin
      chain_din = w[i]; shift_clk = 1'b0;
      wcyc(H);
      seen[i] = chain_dout;
      shift_clk = 1'b1;
      wcyc(H);
    end
    shift_clk = 1'b0;
    wcyc(H);
  endtask

  task automatic pulse_load();
    load_strobe = 1'b1; wcyc(H);
    load_strobe = 1'b0; wcyc(H);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [3:0] seen;
    wcyc(4);
    rst = 1'b0;
    wcyc(2);
    // R7 reset state
    chk("R7 reset drive_en", drive_en, 4'b0);
    chk("R7 reset dout/pull", {2'b0, chain_dout, fault_pull}, 4'b0);

    // R1 / R2: word order and commit on load
    send_word(4'b1011, seen);
    chk("R2 drive_en held before load", drive_en, 4'b0000);
    pulse_load();
    chk("R1 channel order after load", drive_en, 4'b1011);

    // R6 sticky fault
    fault_flags = 4'b0100; wcyc(2);
    fault_flags = 4'b0000; wcyc(4);
    chk("R6 fault_pull sticky", {3'b0, fault_pull}, 4'b0001);
    pulse_load();
    chk("R3 dout shows ch4 fault right after load", {3'b0, chain_dout}, 4'b0000);
    send_word(4'b0110, seen);
    chk("R3 fault readback order", seen, 4'b0100);
    // R4 pass-through: previously shifted word comes out next
    send_word(4'b0000, seen);
    chk("R4 earlier data passes through", seen, 4'b0110);
    pulse_load();
    chk("R2 commit second word", drive_en, 4'b0000);

    // R8 disable
    send_word(4'b1101, seen);
    drive_disable = 1'b1;
    pulse_load();
    chk("R8 drive off while disabled", drive_en, 4'b0000);
    drive_disable = 1'b0; wcyc(2);
    chk("R8 word loaded while disabled", drive_en, 4'b1101);

    // R5 coincident load and shift edge
    chain_din = 1'b1; shift_clk = 1'b1; load_strobe = 1'b1; wcyc(H);
    shift_clk = 1'b0; load_strobe = 1'b0; wcyc(H);
    send_word(4'b0000, seen);
    chk("R5 load beats shift edge", seen, 4'b0100);

    // R7 clear
    clear_req = 1'b1; wcyc(1);
    clear_req = 1'b0; wcyc(1);
    chk("R7 clear drive_en", drive_en, 4'b0);
    chk("R7 clear dout/pull", {2'b0, chain_dout, fault_pull}, 4'b0);

    // random traffic against the model
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 3) == 0) shift_clk = ~shift_clk;
      if ($urandom_range(0, 3) == 0) chain_din = $urandom_range(0, 1);
      if ($urandom_range(0, 40) == 0) load_strobe = ~load_strobe;
      if ($urandom_range(0, 60) == 0) drive_disable = ~drive_disable;
      fault_flags = ($urandom_range(0, 150) == 0) ? 4'($urandom_range(1, 15)) : 4'b0;
      clear_req = ($urandom_range(0, 400) == 0);
      wcyc(1);
    end
    clear_req = 1'b0;
    wcyc(4);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule